// File: doc/BRIEF.md
# Multiplicatively Masked Field Inverter

This block computes the non-linear core of the AES byte substitution on data that is protected by an additive mask. It takes a byte carrying the masked value A+X, the additive mask X, and a nonzero multiplicative mask Y. It returns A^-1+X, which is the field inverse of A under the same additive mask. The affine step, the generation of masks and the rest of the cipher live outside this block.

The additive mask is converted into a multiplicative one before the inversion, and it is converted back afterwards. The unmasked value A is therefore never formed anywhere in the datapath. The first conversion multiplies the masked byte by Y and cancels X·Y, which gives A·Y. That value is inverted to A^-1·Y^-1. The block then adds X·Y^-1 and multiplies by Y, which restores the additive form. The datapath uses four field multipliers, two field inverters and two byte additions.

A parameter selects between two output stages. One is a purely combinational output. The other is a single output register that loads together with a valid flag. A value of A=0 produces a zero intermediate for every Y, so this masking style cannot hide a zero input. This is a known property of the scheme.

Top module: `mmi_masked_inv`

## Requirements
- R1: For every A and X and every nonzero Y, the output equals inv(A) XOR X. Here inv is the multiplicative inverse in GF(2^8) reduced by x^8+x^4+x^3+x+1, and the input byte is A XOR X.
- R2: When the masked byte equals the mask (A=0), the output equals X. The inverse of zero is taken as zero.
- R3: For a fixed A and X, the output is the same for all 255 nonzero values of Y.
- R4: With the output register enabled, valid_out equals valid_in from one clock earlier. The data of a valid input appears one cycle after that input is presented.
- R5: While rst_n is low, the registered variant drives valid_out to 0 and inv_masked to 0.
- R6: With the output register enabled, inv_masked keeps its value in every cycle that follows one with valid_in low.
- R7: Y=0 is illegal while valid_in is high. While valid_in is low, any Y, including zero, has no effect on the outputs.
- R8: With the output register disabled, valid_out follows valid_in in the same cycle, and inv_masked carries the R1 result combinationally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Active-low asynchronous reset |
| valid_in | input | 1 | Input byte and masks are valid |
| a_masked | input | 8 | Additively masked data A XOR X |
| mask_x | input | 8 | Additive mask X |
| mask_y | input | 8 | Multiplicative mask Y, nonzero when valid |
| valid_out | output | 1 | Result is valid |
| inv_masked | output | 8 | Masked inverse inv(A) XOR X |

## Verification
The hardest case is the one where the masked input equals its own mask. In that case A=0, the multiplicatively masked intermediate collapses to zero, and the back-conversion must rebuild X from the correction term alone. The stimulus reaches this case 256 times by sweeping every pair of masked byte and mask. A second sweep holds a few (A, X) pairs fixed and walks Y through all 255 nonzero values, including the zero pair, to show that the output does not depend on Y. The idle cycles drive Y=0 together with changing data to show that illegal masks are harmless when nothing is valid.

// File: rtl/mmi_pkg.sv
package mmi_pkg;
  localparam int GF_W = 8;
  // low bits of the reduction polynomial x^8+x^4+x^3+x+1
  localparam logic [GF_W-1:0] GF_POLY = 8'h1B;
  localparam int GF_INV_STEPS = GF_W - 1;

  typedef logic [GF_W-1:0] gf_t;

  // shift-and-add multiply with reduction on every shift
  function automatic gf_t gf_mul(gf_t a, gf_t b);
    gf_t acc;
    gf_t sh;
    acc = '0;
    sh  = a;
    for (int i = 0; i < GF_W; i++) begin
      if (b[i]) acc = acc ^ sh;
      if (sh[GF_W-1]) sh = (sh << 1) ^ GF_POLY;
      else            sh = sh << 1;
    end
    return acc;
  endfunction

  // a^(2^W - 2) by repeated squaring; zero maps to zero
  function automatic gf_t gf_inv(gf_t a);
    gf_t sq;
    gf_t r;
    sq = a;
    r  = gf_t'(1);
    for (int i = 0; i < GF_INV_STEPS; i++) begin
      sq = gf_mul(sq, sq);
      r  = gf_mul(r, sq);
    end
    return r;
  endfunction
endpackage

// File: rtl/mmi_gf_mul.sv
module mmi_gf_mul
  import mmi_pkg::*;
(
  input  logic [GF_W-1:0] op_a,
  input  logic [GF_W-1:0] op_b,
  output logic [GF_W-1:0] prod
);
  assign prod = gf_mul(op_a, op_b);
endmodule

// File: rtl/mmi_gf_inv.sv
module mmi_gf_inv
  import mmi_pkg::*;
(
  input  logic [GF_W-1:0] din,
  output logic [GF_W-1:0] dout
);
  assign dout = gf_inv(din);

  // a nonzero operand times its inverse gives one (R1)
  always_comb begin
    if (!$isunknown(din) && din != '0) begin
      p_inverse_r1: assert (gf_mul(din, dout) == gf_t'(1))
        else $error("inverse check failed for %h", din);
    end
  end
endmodule

// File: rtl/mmi_masked_inv.sv
module mmi_masked_inv
  import mmi_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            valid_in,
  input  logic [GF_W-1:0] a_masked,
  input  logic [GF_W-1:0] mask_x,
  input  logic [GF_W-1:0] mask_y,
  output logic            valid_out,
  output logic [GF_W-1:0] inv_masked
);
  // named internal events of the datapath
  logic [GF_W-1:0] prod_masked;   // (A+X)*Y
  logic [GF_W-1:0] prod_xy;       // X*Y
  logic [GF_W-1:0] y_inv;         // Y^-1
  logic [GF_W-1:0] a_mulmask;     // A*Y
  logic [GF_W-1:0] inv_mulmask;   // A^-1*Y^-1
  logic [GF_W-1:0] corr_xyinv;    // X*Y^-1
  logic [GF_W-1:0] remask_mul;    // (A^-1+X)*Y^-1
  logic [GF_W-1:0] result;        // A^-1+X
  logic            am_zero;       // multiplicative form collapsed to zero

  // additive -> multiplicative
  mmi_gf_mul u_mul_in   (.op_a(a_masked),   .op_b(mask_y), .prod(prod_masked));
  mmi_gf_mul u_mul_xy   (.op_a(mask_x),     .op_b(mask_y), .prod(prod_xy));
  assign a_mulmask = prod_masked ^ prod_xy;
  assign am_zero   = (a_mulmask == '0);

  // inversions
  mmi_gf_inv u_inv_y    (.din(mask_y),      .dout(y_inv));
  mmi_gf_inv u_inv_core (.din(a_mulmask),   .dout(inv_mulmask));

  // multiplicative -> additive
  mmi_gf_mul u_mul_corr (.op_a(mask_x),     .op_b(y_inv),  .prod(corr_xyinv));
  assign remask_mul = inv_mulmask ^ corr_xyinv;
  mmi_gf_mul u_mul_out  (.op_a(remask_mul), .op_b(mask_y), .prod(result));

  generate
    if (REG_OUT) begin : g_reg
      logic            vld_q;
      logic [GF_W-1:0] data_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          vld_q  <= 1'b0;
          data_q <= '0;
        end else begin
          vld_q <= valid_in;
          if (valid_in) data_q <= result;
        end
      end
      assign valid_out  = vld_q;
      assign inv_masked = data_q;

      p_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
        valid_in |=> valid_out);
      p_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_in |=> !valid_out);
      p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_in |=> $stable(inv_masked));
    end else begin : g_comb
      assign valid_out  = valid_in;
      assign inv_masked = result;
    end
  endgenerate

  // illegal multiplicative mask while data is valid (R7)
  p_mask_nonzero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    valid_in |-> (mask_y != '0));

  // the zero intermediate appears exactly for A=0 (R2, known exposure)
  always_comb begin
    if (valid_in && !$isunknown({a_masked, mask_x, mask_y}) && mask_y != '0) begin
      p_zero_exposed_r2: assert (am_zero == (a_masked == mask_x))
        else $error("zero intermediate mismatch");
    end
  end
endmodule

// File: tb/sim_mmi_masked_inv.sv
module sim_mmi_masked_inv;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       valid_in = 1'b0;
  logic [7:0] a_masked = '0;
  logic [7:0] mask_x = '0;
  logic [7:0] mask_y = '0;
  logic       v0, v1;
  logic [7:0] d0, d1;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  logic [7:0] exp_t [0:255];
  int         log_t [0:255];
  logic [7:0] last_d0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mmi_masked_inv #(.REG_OUT(1'b1)) u0 (.clk(clk), .rst_n(rst_n), .valid_in(valid_in),
    .a_masked(a_masked), .mask_x(mask_x), .mask_y(mask_y), .valid_out(v0), .inv_masked(d0));
  mmi_masked_inv #(.REG_OUT(1'b0)) u1 (.clk(clk), .rst_n(rst_n), .valid_in(valid_in),
    .a_masked(a_masked), .mask_x(mask_x), .mask_y(mask_y), .valid_out(v1), .inv_masked(d1));

  function automatic logic [7:0] xtime(logic [7:0] v);
    return v[7] ? ({v[6:0], 1'b0} ^ 8'h1B) : {v[6:0], 1'b0};
  endfunction

  // inverse through logarithm tables with generator 3
  function automatic logic [7:0] ref_inv(logic [7:0] a);
    if (a == 8'h00) return 8'h00;
    return exp_t[(255 - log_t[a]) % 255];
  endfunction

  task automatic check(string req, logic [7:0] got, logic [7:0] expv);
    checks++;
    if (got !== expv) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, expv);
    end
  endtask

  task automatic apply(string req, logic [7:0] a, logic [7:0] x, logic [7:0] y);
    logic [7:0] e;
    e = ref_inv(a) ^ x;
    @(negedge clk);
    valid_in = 1'b1;
    a_masked = a ^ x;
    mask_x   = x;
    mask_y   = y;
    #1;
    check("R8 valid", {7'b0, v1}, 8'h01);
    check(req, d1, e);
    @(posedge clk);
    #1;
    check("R4 valid", {7'b0, v0}, 8'h01);
    check(req, d0, e);
    last_d0 = e;
  endtask

  initial begin
    logic [7:0] v;
    v = 8'h01;
    log_t[0] = 0;
    for (int i = 0; i < 255; i++) begin
      exp_t[i] = v;
      log_t[v] = i;
      v = v ^ xtime(v);
    end
    exp_t[255] = 8'h01;

    // R5: reset state
    repeat (3) @(negedge clk);
    check("R5 valid", {7'b0, v0}, 8'h00);
    check("R5 data", d0, 8'h00);
    rst_n = 1'b1;

    // R1, R2: every A and X, Y spread over all nonzero values
    for (int a = 0; a < 256; a++) begin
      for (int x = 0; x < 256; x++) begin
        apply((a == 0) ? "R2" : "R1", 8'(a), 8'(x), 8'(((a * 7 + x * 13) % 255) + 1));
      end
    end

    // R3: fixed A, X across all nonzero Y, zero input included
    for (int k = 0; k < 3; k++) begin
      for (int y = 1; y < 256; y++) begin
        apply("R3", (k == 0) ? 8'h53 : (k == 1) ? 8'h00 : 8'hFF, 8'h1C, 8'(y));
      end
    end

    // R6, R7: idle cycles with Y=0 and moving data
    for (int n = 0; n < 8; n++) begin
      @(negedge clk);
      valid_in = 1'b0;
      mask_y   = 8'h00;
      a_masked = 8'(n * 37 + 5);
      mask_x   = 8'(n * 11);
      @(posedge clk);
      #1;
      check("R4 idle", {7'b0, v0}, 8'h00);
      check("R6 R7 hold", d0, last_d0);
      check("R8 idle", {7'b0, v1}, 8'h00);
    end

    $display("NOTE: known limitation R2: A=0 gives a zero multiplicative intermediate for every Y, so zero is not hidden");
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule